// File: doc/BRIEF.md
# Multithreaded Instruction Issue Scheduler

This block sits in front of the issue stage of a processor core that holds many hardware thread contexts. Each cycle it chooses one thread to issue an instruction and presents that thread's number with a valid strobe. A thread can be chosen only if it is switched on and has no load or store in flight. After a thread issues, the next search begins at the thread just after it, so every ready thread gets a turn. Inactive or stalled threads are skipped within the same cycle, so the block never idles on an empty slot while another thread is ready.

A front end reports, for each thread, whether that thread's next instruction is a load or store. When such a thread is chosen, it is marked as waiting for memory and drops out of selection. It returns once the memory system sends back a completion tagged with its thread number. Any number of threads may wait on memory at once while the others keep issuing. The choice is made from the inputs of one cycle and is registered, so it appears on the outputs after the next clock edge.

Top module: `mt_issue_sched`

## Requirements
- R1: While `rst` is high at a clock edge, the block clears every waiting-for-memory mark, sets the search start to thread 0 and drives `issue_valid` low after that edge.
- R2: A thread is eligible when its `thread_active` bit is 1 and it has no memory operation waiting. When at least one thread is eligible in a cycle, the next edge drives `issue_valid` high with an eligible thread on `issue_tid`. When none is eligible, `issue_valid` is low after that edge.
- R3: The search starts one thread past the most recently issued thread and wraps from the highest thread number to thread 0. It returns the first eligible thread in that circular order and skips every ineligible thread in the same cycle.
- R4: In a cycle with no eligible thread, the search start keeps its value.
- R5: A thread chosen while its `mem_next` bit is 1 becomes ineligible from the next cycle on. A `mem_next` bit of a thread that is not chosen has no effect.
- R6: When `cmp_valid` is 1, the thread numbered by `cmp_tid` loses its waiting mark at that edge and can be chosen by the selection of the following cycle. Any number of threads may wait at once.
- R7: If a thread is chosen with its `mem_next` bit set in the same cycle that a completion names it, the thread stays marked as waiting.
- R8: A change of `thread_active` applies to the selection of the same cycle, and so to the outputs after the next edge. Clearing a thread's active bit does not remove its waiting mark.
- R9: `issue_valid` and `issue_tid` are registered. They show the choice made from the inputs of the previous cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| thread_active | input | NUM_THREADS | One bit per thread: thread is switched on |
| mem_next | input | NUM_THREADS | One bit per thread: its next instruction is a load or store |
| cmp_valid | input | 1 | A memory completion is reported this cycle |
| cmp_tid | input | TID_W | Thread number of the completed memory operation |
| issue_valid | output | 1 | A thread was chosen to issue |
| issue_tid | output | TID_W | Thread number chosen to issue |

## Verification
The bench builds two copies of the block. The main copy has eight threads, which keeps the circular search short enough to test by hand: wrap-around, holding the start while nothing is ready, and the wait and release of several threads at once. The second copy uses the full 128 threads with 7-bit thread numbers. It checks the wrap from thread 127 back to 0 and a completion tagged with the top thread number.

// File: rtl/sched_pkg.sv
package sched_pkg;

  localparam int unsigned DEF_THREADS = 128;

  // Next-state decision for one thread's memory-wait flag.
  typedef enum logic [1:0] {
    WAIT_HOLD  = 2'd0,
    WAIT_ARM   = 2'd1,
    WAIT_CLEAR = 2'd2
  } wait_op_e;

endpackage

// File: rtl/sched_wait_track.sv
module sched_wait_track
  import sched_pkg::*;
#(
  parameter int unsigned NUM_THREADS = DEF_THREADS,
  parameter int unsigned TID_W       = $clog2(NUM_THREADS)
) (
  input  logic                   clk,
  input  logic                   rst,
  input  logic                   arm_en,
  input  logic [TID_W-1:0]       arm_tid,
  input  logic                   clr_en,
  input  logic [TID_W-1:0]       clr_tid,
  output logic [NUM_THREADS-1:0] wait_q
);

  for (genvar t = 0; t < NUM_THREADS; t++) begin : g_thr
    wait_op_e op;

    // Arming wins over a completion that names the same thread (R7).
    always_comb begin
      if (arm_en && arm_tid == TID_W'(t))
        op = WAIT_ARM;
      else if (clr_en && clr_tid == TID_W'(t))
        op = WAIT_CLEAR;
      else
        op = WAIT_HOLD;
    end

    always_ff @(posedge clk) begin
      if (rst) begin
        wait_q[t] <= 1'b0;
      end else begin
        case (op)
          WAIT_ARM:   wait_q[t] <= 1'b1;
          WAIT_CLEAR: wait_q[t] <= 1'b0;
          default:    wait_q[t] <= wait_q[t];
        endcase
      end
    end
  end

endmodule

// File: rtl/sched_low_enc.sv
module sched_low_enc #(
  parameter int unsigned WIDTH = 128,
  parameter int unsigned IDX_W = $clog2(WIDTH)
) (
  input  logic [WIDTH-1:0] vec,
  output logic             found,
  output logic [IDX_W-1:0] idx
);

  always_comb begin
    found = |vec;
    idx   = '0;
    for (int i = WIDTH - 1; i >= 0; i--) begin
      if (vec[i]) idx = IDX_W'(i);
    end
  end

endmodule

// File: rtl/sched_ring_pick.sv
module sched_ring_pick #(
  parameter int unsigned NUM_THREADS = 128,
  parameter int unsigned TID_W       = $clog2(NUM_THREADS)
) (
  input  logic [NUM_THREADS-1:0] elig,
  input  logic [TID_W-1:0]       start,
  output logic                   found,
  output logic [TID_W-1:0]       tid
);

  logic [NUM_THREADS-1:0] at_or_above;
  logic [NUM_THREADS-1:0] upper_elig;
  logic                   up_found;
  logic                   all_found;
  logic [TID_W-1:0]       up_idx;
  logic [TID_W-1:0]       all_idx;

  for (genvar i = 0; i < NUM_THREADS; i++) begin : g_mask
    assign at_or_above[i] = (TID_W'(i) >= start);
  end

  assign upper_elig = elig & at_or_above;

  // Two parallel lowest-index searches: one from the start, one wrapped.
  sched_low_enc #(.WIDTH(NUM_THREADS), .IDX_W(TID_W)) u_enc_upper (
    .vec   (upper_elig),
    .found (up_found),
    .idx   (up_idx)
  );

  sched_low_enc #(.WIDTH(NUM_THREADS), .IDX_W(TID_W)) u_enc_all (
    .vec   (elig),
    .found (all_found),
    .idx   (all_idx)
  );

  assign found = all_found;
  assign tid   = up_found ? up_idx : all_idx;

endmodule

// File: rtl/mt_issue_sched.sv
module mt_issue_sched
  import sched_pkg::*;
#(
  parameter int unsigned NUM_THREADS = DEF_THREADS,
  parameter int unsigned TID_W       = $clog2(NUM_THREADS)
) (
  input  logic                   clk,
  input  logic                   rst,
  input  logic [NUM_THREADS-1:0] thread_active,
  input  logic [NUM_THREADS-1:0] mem_next,
  input  logic                   cmp_valid,
  input  logic [TID_W-1:0]       cmp_tid,
  output logic                   issue_valid,
  output logic [TID_W-1:0]       issue_tid
);

  localparam logic [TID_W-1:0] LAST_TID = TID_W'(NUM_THREADS - 1);

  logic [NUM_THREADS-1:0] pend_vec;
  logic [NUM_THREADS-1:0] elig;
  logic [TID_W-1:0]       start_q;
  logic                   pick_found;
  logic [TID_W-1:0]       set_tid;
  logic                   set_fire;

  assign elig = thread_active & ~pend_vec;

  sched_ring_pick #(.NUM_THREADS(NUM_THREADS), .TID_W(TID_W)) u_pick (
    .elig  (elig),
    .start (start_q),
    .found (pick_found),
    .tid   (set_tid)
  );

  assign set_fire = pick_found && mem_next[set_tid];

  sched_wait_track #(.NUM_THREADS(NUM_THREADS), .TID_W(TID_W)) u_wait (
    .clk     (clk),
    .rst     (rst),
    .arm_en  (set_fire),
    .arm_tid (set_tid),
    .clr_en  (cmp_valid),
    .clr_tid (cmp_tid),
    .wait_q  (pend_vec)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      issue_valid <= 1'b0;
      issue_tid   <= '0;
      start_q     <= '0;
    end else begin
      issue_valid <= pick_found;
      if (pick_found) begin
        issue_tid <= set_tid;
        start_q   <= (set_tid == LAST_TID) ? '0 : set_tid + 1'b1;
      end
    end
  end

endmodule

// File: rtl/mt_issue_sched_chk.sv
module mt_issue_sched_chk #(
  parameter int unsigned NUM_THREADS = 128,
  parameter int unsigned TID_W       = $clog2(NUM_THREADS)
) (
  input logic                   clk,
  input logic                   rst,
  input logic [NUM_THREADS-1:0] thread_active,
  input logic                   cmp_valid,
  input logic [TID_W-1:0]       cmp_tid,
  input logic                   issue_valid,
  input logic [TID_W-1:0]       issue_tid,
  input logic [NUM_THREADS-1:0] pend_vec,
  input logic [TID_W-1:0]       start_q,
  input logic                   pick_found,
  input logic                   set_fire,
  input logic [TID_W-1:0]       set_tid
);

  logic                   rst_d;
  logic [NUM_THREADS-1:0] act_d;
  logic [NUM_THREADS-1:0] pend_d;

  always_ff @(posedge clk) begin
    rst_d  <= rst;
    act_d  <= thread_active;
    pend_d <= pend_vec;
  end

  // R1: a reset edge leaves the block idle with cleared state
  always @(posedge clk) begin
    if (rst_d === 1'b1) begin
      p_reset_idle_r1: assert (!issue_valid && start_q == '0 && pend_vec == '0)
        else $error("p_reset_idle_r1");
    end
  end

  // R2, R9: an issued thread was active and not waiting in the previous cycle
  p_elig_sel_r2: assert property (@(posedge clk) disable iff (rst || rst_d)
    issue_valid |-> (act_d[issue_tid] && !pend_d[issue_tid]))
    else $error("p_elig_sel_r2");

  // R2: the strobe follows whether any thread was ready
  p_valid_any_r2: assert property (@(posedge clk) disable iff (rst || rst_d)
    issue_valid == |(act_d & ~pend_d))
    else $error("p_valid_any_r2");

  // R4: no choice keeps the search start
  p_ptr_hold_r4: assert property (@(posedge clk) disable iff (rst)
    !pick_found |=> start_q == $past(start_q))
    else $error("p_ptr_hold_r4");

  // R5: a chosen memory instruction marks its thread as waiting
  p_mem_block_r5: assert property (@(posedge clk) disable iff (rst)
    set_fire |=> pend_vec[$past(set_tid)])
    else $error("p_mem_block_r5");

  // R5: the same thread is never issued twice in a row after a memory issue
  p_no_reissue_r5: assert property (@(posedge clk) disable iff (rst)
    set_fire |=> !(pick_found && set_tid == $past(set_tid)))
    else $error("p_no_reissue_r5");

  // R6: a completion releases its thread
  p_cmp_clear_r6: assert property (@(posedge clk) disable iff (rst)
    (cmp_valid && !(set_fire && set_tid == cmp_tid)) |=> !pend_vec[$past(cmp_tid)])
    else $error("p_cmp_clear_r6");

  // R7: a new memory issue outranks a completion for the same thread
  p_same_cycle_r7: assert property (@(posedge clk) disable iff (rst)
    (set_fire && cmp_valid && cmp_tid == set_tid) |=> pend_vec[$past(cmp_tid)])
    else $error("p_same_cycle_r7");

endmodule

bind mt_issue_sched mt_issue_sched_chk #(
  .NUM_THREADS (NUM_THREADS),
  .TID_W       (TID_W)
) u_chk (
  .clk           (clk),
  .rst           (rst),
  .thread_active (thread_active),
  .cmp_valid     (cmp_valid),
  .cmp_tid       (cmp_tid),
  .issue_valid   (issue_valid),
  .issue_tid     (issue_tid),
  .pend_vec      (pend_vec),
  .start_q       (start_q),
  .pick_found    (pick_found),
  .set_fire      (set_fire),
  .set_tid       (set_tid)
);

// File: tb/mt_issue_sched_bench.sv
`timescale 1ns/1ps
module mt_issue_sched_bench;

  localparam int N_S = 8;
  localparam int W_S = 3;
  localparam int N_W = 128;
  localparam int W_W = 7;
  localparam int NVEC = 25;

  logic clk = 1'b0;
  logic rst = 1'b1;
  always #2 clk = ~clk;  // 250 MHz

  logic [N_S-1:0] act_s = '0, mem_s = '0;
  logic           cv_s = 1'b0;
  logic [W_S-1:0] ct_s = '0;
  logic           iv_s;
  logic [W_S-1:0] it_s;

  logic [N_W-1:0] act_w = '0, mem_w = '0;
  logic           cv_w = 1'b0;
  logic [W_W-1:0] ct_w = '0;
  logic           iv_w;
  logic [W_W-1:0] it_w;

  mt_issue_sched #(.NUM_THREADS(N_S), .TID_W(W_S)) u_mt_issue_sched (
    .clk(clk), .rst(rst), .thread_active(act_s), .mem_next(mem_s),
    .cmp_valid(cv_s), .cmp_tid(ct_s), .issue_valid(iv_s), .issue_tid(it_s));

  mt_issue_sched #(.NUM_THREADS(N_W), .TID_W(W_W)) u_mt_issue_sched_w (
    .clk(clk), .rst(rst), .thread_active(act_w), .mem_next(mem_w),
    .cmp_valid(cv_w), .cmp_tid(ct_w), .issue_valid(iv_w), .issue_tid(it_w));

  int n_tests = 0;
  int n_fail  = 0;

  // {active[7:0], mem_next[7:0], cmp_valid, cmp_tid[2:0], exp_valid, exp_tid[2:0]}
  localparam logic [23:0] VEC [NVEC] = '{
    {8'hFF, 8'h00, 1'b0, 3'd0, 1'b1, 3'd0},
    {8'hFF, 8'h00, 1'b0, 3'd0, 1'b1, 3'd1},
    {8'hFF, 8'h04, 1'b0, 3'd0, 1'b1, 3'd2},
    {8'hFF, 8'h08, 1'b0, 3'd0, 1'b1, 3'd3},
    {8'h0C, 8'h00, 1'b0, 3'd0, 1'b0, 3'd0},
    {8'h0C, 8'h00, 1'b1, 3'd2, 1'b0, 3'd0},
    {8'h0C, 8'h00, 1'b0, 3'd0, 1'b1, 3'd2},
    {8'h0C, 8'h00, 1'b1, 3'd3, 1'b1, 3'd2},
    {8'h0C, 8'h00, 1'b0, 3'd0, 1'b1, 3'd3},
    {8'h81, 8'h00, 1'b0, 3'd0, 1'b1, 3'd7},
    {8'h81, 8'h00, 1'b0, 3'd0, 1'b1, 3'd0},
    {8'h01, 8'h01, 1'b1, 3'd0, 1'b1, 3'd0},
    {8'h01, 8'h00, 1'b0, 3'd0, 1'b0, 3'd0},
    {8'h01, 8'h00, 1'b0, 3'd0, 1'b0, 3'd0},
    {8'h00, 8'h00, 1'b1, 3'd0, 1'b0, 3'd0},
    {8'h01, 8'h00, 1'b0, 3'd0, 1'b1, 3'd0},
    {8'h20, 8'h20, 1'b0, 3'd0, 1'b1, 3'd5},
    {8'h00, 8'h00, 1'b0, 3'd0, 1'b0, 3'd0},
    {8'h20, 8'h00, 1'b0, 3'd0, 1'b0, 3'd0},
    {8'h20, 8'h00, 1'b1, 3'd5, 1'b0, 3'd0},
    {8'h20, 8'h00, 1'b0, 3'd0, 1'b1, 3'd5},
    {8'h60, 8'h20, 1'b0, 3'd0, 1'b1, 3'd6},
    {8'h20, 8'h00, 1'b0, 3'd0, 1'b1, 3'd5},
    {8'h00, 8'h00, 1'b0, 3'd0, 1'b0, 3'd0},
    {8'h41, 8'h00, 1'b0, 3'd0, 1'b1, 3'd6}
  };

  localparam string VTAG [NVEC] = '{
    "R3", "R3", "R5", "R5", "R2", "R6", "R6", "R6", "R6", "R3",
    "R3", "R7", "R7", "R7", "R6", "R6", "R5", "R8", "R8", "R8",
    "R8", "R5", "R5", "R4", "R4"
  };

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_tests++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: got %0d expected %0d", tag, act, exp);
    end
  endtask

  task automatic tick();
    @(posedge clk);
    #1;
  endtask

  task automatic chk_s(input string tag, input logic ev, input logic [W_S-1:0] et);
    check(tag, {31'd0, iv_s}, {31'd0, ev});
    if (ev) check(tag, {29'd0, it_s}, {29'd0, et});
  endtask

  task automatic chk_w(input string tag, input logic ev, input logic [W_W-1:0] et);
    check(tag, {31'd0, iv_w}, {31'd0, ev});
    if (ev) check(tag, {25'd0, it_w}, {25'd0, et});
  endtask

  int cycles = 0;
  always @(posedge clk) begin
    cycles++;
    if (cycles > 20000) begin
      n_fail++;
      n_tests++;
      $display("FAIL watchdog: got %0d cycles expected below 20000", cycles);
      $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end

  initial begin
    rst = 1'b1;
    act_s = 8'hFF;
    tick();
    tick();
    chk_s("R1", 1'b0, '0);  // held in reset with active threads
    rst = 1'b0;

    // vector table on the eight-thread copy
    for (int v = 0; v < NVEC; v++) begin
      act_s = VEC[v][23:16];
      mem_s = VEC[v][15:8];
      cv_s  = VEC[v][7];
      ct_s  = VEC[v][6:4];
      tick();
      chk_s(VTAG[v], VEC[v][3], VEC[v][2:0]);
    end

    // R1: reset clears a waiting thread and the search start
    act_s = 8'h08; mem_s = 8'h08; cv_s = 1'b0;
    tick();
    chk_s("R5", 1'b1, 3'd3);
    mem_s = 8'h00;
    rst = 1'b1;
    tick();
    chk_s("R1", 1'b0, '0);
    rst = 1'b0;
    act_s = 8'hFF;
    tick();
    chk_s("R1", 1'b1, 3'd0);
    act_s = 8'h08;
    tick();
    chk_s("R1", 1'b1, 3'd3);

    // R6: all eight threads waiting at once, then one released
    act_s = 8'hFF; mem_s = 8'hFF;
    for (int k = 0; k < 8; k++) begin
      tick();
      chk_s("R6", 1'b1, W_S'((4 + k) % 8));
    end
    tick();
    chk_s("R6", 1'b0, '0);
    cv_s = 1'b1; ct_s = 3'd6;
    tick();
    chk_s("R6", 1'b0, '0);
    cv_s = 1'b0;
    tick();
    chk_s("R6", 1'b1, 3'd6);
    act_s = 8'h00; mem_s = 8'h00;

    // 128-thread copy: wrap at the top and a 7-bit completion tag
    act_w = '0;
    act_w[127] = 1'b1;
    tick();
    chk_w("R3", 1'b1, 7'd127);
    act_w[0] = 1'b1;
    act_w[64] = 1'b1;
    tick();
    chk_w("R3", 1'b1, 7'd0);
    tick();
    chk_w("R3", 1'b1, 7'd64);
    mem_w[127] = 1'b1;
    tick();
    chk_w("R5", 1'b1, 7'd127);
    mem_w = '0;
    tick();
    chk_w("R3", 1'b1, 7'd0);
    cv_w = 1'b1; ct_w = 7'd127;
    tick();
    chk_w("R6", 1'b1, 7'd64);
    cv_w = 1'b0;
    tick();
    chk_w("R6", 1'b1, 7'd127);

    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

endmodule